// File: doc/BRIEF.md
# DPLL Tight-Lock Loop Parameter Selector

This block picks, from moment to moment, the bandwidth, damping and gain codes that a digital PLL loop filter should apply. It watches a stream of signed phase-error samples and a phase-locked flag, and places the loop in one of three operating regions: acquisition, normal lock or tight lock. Tight lock is a finer loop setting that is used only while the loop is locked and the phase error is small. Entry to and exit from tight lock follow a programmable threshold. An optional hysteresis rule makes entry much stricter than exit.

Phase-error samples arrive on a valid/ready interface. `err_ready` is low during reset and rises on the first clock edge after reset is released. From then on it stays high, so the block never applies back-pressure. A sample is accepted on any edge where both `err_valid` and `err_ready` are high. A source may hold `err_valid` high with the same data, and each cycle counts as a new sample.

Phase error is a two's complement count. Its LSB is the threshold base unit, which is also taken as the lock-window step. All selected codes are registered. They update only when a sample is accepted or when the locked flag changes. Configuration changes made at other times have no effect until the next such event.

Top module: `dpll_tlk_select`

## Requirements
- R1: During and right after reset: `tight_lock`=0, `in_window`=0, `win_cfg_err`=0, `sel_src`=2'b01, `sel_bw`=0, `sel_damp`=0 and `sel_gain`=2'b01. `err_ready` is 0 while `rst_n` is low.
- R2: On each update event, `sel_gain` takes `cfg_gain` unchanged. Codes 00, 01, 10 and 11 mean loop gains of 0.5, 1.0, 1.5 and 2.0.
- R3: With `cfg_hyst_en`=0, let T = `cfg_tl_thr`+2. An accepted sample with |err| < T enters tight lock. A sample with |err| > T leaves tight lock. |err| = T keeps the present state.
- R4: With `cfg_hyst_en`=1, tight lock is entered only on a sample with |err| < 2 (the fine entry limit). It is left on a sample with |err| > T, where T is as defined in R3.
- R5: Tight lock can only be set while `phase_locked`=1. When `phase_locked`=0 is seen at an edge, tight lock is cleared on that edge, and samples taken while unlocked never set it.
- R6: In tight lock, `sel_src`=2'b10. `sel_bw` is {1'b0,`cfg_tl_bw`}, or `cfg_lck_bw` when `cfg_tl_bw`=0. `sel_damp` is `cfg_tl_damp`, or `cfg_lck_damp` when `cfg_tl_damp` is 0, 6 or 7.
- R7: Outside tight lock with `cfg_fast_lock`=1 and `phase_locked`=0, the acquisition codes are used and `sel_src`=2'b00. In every other non-tight case, the locked codes are used and `sel_src`=2'b01.
- R8: On each accepted sample, `in_window` = (|err| <= W), where W = `cfg_lock_win`, or W = 1 when that field is 0. `win_cfg_err` is high one cycle after `cfg_lock_win`=0 is present and low one cycle after it is nonzero.
- R9: If no sample is accepted and `phase_locked` equals its value at the previous edge, then `sel_*` and `tight_lock` keep their values, whatever happens on the configuration inputs.
- R10: `err_ready` becomes 1 on the first edge after reset is released and stays 1 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Phase-error sample valid |
| err_ready | output | 1 | Sample accepted when high with valid |
| err_data | input | ERR_W | Signed phase error, threshold-unit LSB |
| phase_locked | input | 1 | Loop phase-locked flag |
| cfg_gain | input | 2 | Loop gain code |
| cfg_tl_bw | input | 3 | Tight-lock bandwidth code, 0 = use locked |
| cfg_tl_damp | input | 3 | Tight-lock damping code, 0/6/7 = use locked |
| cfg_hyst_en | input | 1 | Hysteresis rule enable |
| cfg_tl_thr | input | THR_W | Tight-lock threshold field |
| cfg_fast_lock | input | 1 | Use acquisition codes until locked |
| cfg_lck_bw | input | BW_W | Locked bandwidth code |
| cfg_lck_damp | input | 3 | Locked damping code |
| cfg_acq_bw | input | BW_W | Acquisition bandwidth code |
| cfg_acq_damp | input | 3 | Acquisition damping code |
| cfg_lock_win | input | WIN_W | Lock window in error LSBs |
| sel_bw | output | BW_W | Selected bandwidth code |
| sel_damp | output | 3 | Selected damping code |
| sel_gain | output | 2 | Selected gain code |
| sel_src | output | 2 | Region: 00 acq, 01 lock, 10 tight |
| tight_lock | output | 1 | Tight-lock status |
| in_window | output | 1 | Last sample inside lock window |
| win_cfg_err | output | 1 | Lock window field programmed to 0 |

## Verification
A corrupted tight-lock state bit appears at the ports on the next update event. It shows as `sel_src` and the bandwidth/damping codes switching to the wrong region, and the scoreboard compares exactly that one cycle after each accepted sample. A lost copy of the previous locked flag would either miss the update after a lock edge or allow spurious updates between samples. The stability check that follows configuration-only changes exposes such a fault within one cycle. Threshold off-by-one faults are aimed at by samples whose magnitude sits exactly at T, T±1, the fine entry limit and the window edge, and by the most-negative error value.

// File: rtl/dpll_tlk_pkg.sv
package dpll_tlk_pkg;

  typedef enum logic [1:0] {
    SRC_ACQ   = 2'b00,
    SRC_LOCK  = 2'b01,
    SRC_TIGHT = 2'b10
  } src_e;

  localparam logic [1:0] GAIN_RST = 2'b01;
  localparam int unsigned DAMP_W = 3;
  localparam int unsigned GAIN_W = 2;

  // damping codes above this value are reserved
  localparam logic [DAMP_W-1:0] DAMP_MAX_LEGAL = 3'd5;

endpackage

// File: rtl/dpll_tlk_mag.sv
module dpll_tlk_mag #(
  parameter int unsigned ERR_W    = 12,
  parameter int unsigned THR_W    = 7,
  parameter int unsigned WIN_W    = 8,
  parameter int unsigned THR_OFS  = 2,
  parameter int unsigned FINE_LIM = 2
) (
  input  logic signed [ERR_W-1:0] err_data,
  input  logic        [THR_W-1:0] thr_code,
  input  logic        [WIN_W-1:0] win_code,
  output logic                    lt_thr,
  output logic                    gt_thr,
  output logic                    lt_fine,
  output logic                    in_win,
  output logic                    win_zero
);
  localparam int unsigned CMP_W = ERR_W + 1;

  logic [ERR_W-1:0] mag;
  logic [CMP_W-1:0] mag_x;
  logic [CMP_W-1:0] thr_eff;
  logic [CMP_W-1:0] win_eff;

  // unsigned magnitude; the most negative value maps to 2^(ERR_W-1)
  always_comb begin
    if (err_data[ERR_W-1]) mag = ERR_W'(-err_data);
    else                   mag = ERR_W'(err_data);
  end

  assign mag_x    = {1'b0, mag};
  assign thr_eff  = CMP_W'(thr_code) + CMP_W'(THR_OFS);
  assign win_zero = (win_code == '0);
  assign win_eff  = win_zero ? CMP_W'(1) : CMP_W'(win_code);

  assign lt_thr  = (mag_x < thr_eff);
  assign gt_thr  = (mag_x > thr_eff);
  assign lt_fine = (mag_x < CMP_W'(FINE_LIM));
  assign in_win  = (mag_x <= win_eff);
endmodule

// File: rtl/dpll_tlk_fsm.sv
module dpll_tlk_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic locked,
  input  logic hyst_en,
  input  logic lt_thr,
  input  logic gt_thr,
  input  logic lt_fine,
  output logic tight_d,
  output logic tight_q
);
  logic enter_ok;

  assign enter_ok = hyst_en ? lt_fine : lt_thr;

  always_comb begin
    tight_d = tight_q;
    if (!locked) begin
      tight_d = 1'b0;
    end else if (accept) begin
      if (tight_q) begin
        if (gt_thr) tight_d = 1'b0;
      end else begin
        if (enter_ok) tight_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tight_q <= 1'b0;
    else        tight_q <= tight_d;
  end
endmodule

// File: rtl/dpll_tlk_codesel.sv
module dpll_tlk_codesel
  import dpll_tlk_pkg::*;
#(
  parameter int unsigned BW_W = 4,
  parameter int unsigned TLBW_W = 3
) (
  input  logic              tight,
  input  logic              locked,
  input  logic              fast_lock,
  input  logic [TLBW_W-1:0] tl_bw,
  input  logic [DAMP_W-1:0] tl_damp,
  input  logic [BW_W-1:0]   lck_bw,
  input  logic [DAMP_W-1:0] lck_damp,
  input  logic [BW_W-1:0]   acq_bw,
  input  logic [DAMP_W-1:0] acq_damp,
  output logic [BW_W-1:0]   bw,
  output logic [DAMP_W-1:0] damp,
  output src_e              src
);
  logic tl_bw_off;
  logic tl_damp_off;

  assign tl_bw_off   = (tl_bw == '0);
  assign tl_damp_off = (tl_damp == '0) || (tl_damp > DAMP_MAX_LEGAL);

  always_comb begin
    if (tight) begin
      src  = SRC_TIGHT;
      bw   = tl_bw_off ? lck_bw : BW_W'(tl_bw);
      damp = tl_damp_off ? lck_damp : tl_damp;
    end else if (fast_lock && !locked) begin
      src  = SRC_ACQ;
      bw   = acq_bw;
      damp = acq_damp;
    end else begin
      src  = SRC_LOCK;
      bw   = lck_bw;
      damp = lck_damp;
    end
  end
endmodule

// File: rtl/dpll_tlk_select.sv
module dpll_tlk_select
  import dpll_tlk_pkg::*;
#(
  parameter int unsigned ERR_W    = 12,
  parameter int unsigned THR_W    = 7,
  parameter int unsigned WIN_W    = 8,
  parameter int unsigned BW_W     = 4,
  parameter int unsigned TLBW_W   = 3,
  parameter int unsigned THR_OFS  = 2,
  parameter int unsigned FINE_LIM = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_valid,
  output logic                     err_ready,
  input  logic signed [ERR_W-1:0]  err_data,
  input  logic                     phase_locked,
  input  logic [1:0]               cfg_gain,
  input  logic [TLBW_W-1:0]        cfg_tl_bw,
  input  logic [2:0]               cfg_tl_damp,
  input  logic                     cfg_hyst_en,
  input  logic [THR_W-1:0]         cfg_tl_thr,
  input  logic                     cfg_fast_lock,
  input  logic [BW_W-1:0]          cfg_lck_bw,
  input  logic [2:0]               cfg_lck_damp,
  input  logic [BW_W-1:0]          cfg_acq_bw,
  input  logic [2:0]               cfg_acq_damp,
  input  logic [WIN_W-1:0]         cfg_lock_win,
  output logic [BW_W-1:0]          sel_bw,
  output logic [2:0]               sel_damp,
  output logic [1:0]               sel_gain,
  output logic [1:0]               sel_src,
  output logic                     tight_lock,
  output logic                     in_window,
  output logic                     win_cfg_err
);
  logic accept;
  logic locked_q;
  logic lock_edge;
  logic update;
  logic lt_thr, gt_thr, lt_fine, in_win_c, win_zero;
  logic tight_d, tight_q;
  logic [BW_W-1:0]   bw_c;
  logic [DAMP_W-1:0] damp_c;
  src_e              src_c;

  assign accept    = err_valid && err_ready;
  assign lock_edge = (phase_locked != locked_q);
  assign update    = accept || lock_edge;

  dpll_tlk_mag #(
    .ERR_W(ERR_W), .THR_W(THR_W), .WIN_W(WIN_W),
    .THR_OFS(THR_OFS), .FINE_LIM(FINE_LIM)
  ) mag_i (
    .err_data(err_data), .thr_code(cfg_tl_thr), .win_code(cfg_lock_win),
    .lt_thr(lt_thr), .gt_thr(gt_thr), .lt_fine(lt_fine),
    .in_win(in_win_c), .win_zero(win_zero)
  );

  dpll_tlk_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .locked(phase_locked),
    .hyst_en(cfg_hyst_en), .lt_thr(lt_thr), .gt_thr(gt_thr),
    .lt_fine(lt_fine), .tight_d(tight_d), .tight_q(tight_q)
  );

  dpll_tlk_codesel #(.BW_W(BW_W), .TLBW_W(TLBW_W)) sel_i (
    .tight(tight_d), .locked(phase_locked), .fast_lock(cfg_fast_lock),
    .tl_bw(cfg_tl_bw), .tl_damp(cfg_tl_damp),
    .lck_bw(cfg_lck_bw), .lck_damp(cfg_lck_damp),
    .acq_bw(cfg_acq_bw), .acq_damp(cfg_acq_damp),
    .bw(bw_c), .damp(damp_c), .src(src_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ready   <= 1'b0;
      locked_q    <= 1'b0;
      sel_bw      <= '0;
      sel_damp    <= '0;
      sel_gain    <= GAIN_RST;
      sel_src     <= SRC_LOCK;
      in_window   <= 1'b0;
      win_cfg_err <= 1'b0;
    end else begin
      err_ready   <= 1'b1;
      locked_q    <= phase_locked;
      win_cfg_err <= win_zero;
      if (update) begin
        sel_bw   <= bw_c;
        sel_damp <= damp_c;
        sel_gain <= cfg_gain;
        sel_src  <= src_c;
      end
      if (accept) in_window <= in_win_c;
    end
  end

  assign tight_lock = tight_q;
endmodule

// File: rtl/dpll_tlk_checker.sv
module dpll_tlk_checker #(
  parameter int unsigned ERR_W = 12,
  parameter int unsigned WIN_W = 8,
  parameter int unsigned BW_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    err_valid,
  input logic                    err_ready,
  input logic signed [ERR_W-1:0] err_data,
  input logic                    phase_locked,
  input logic                    cfg_hyst_en,
  input logic [WIN_W-1:0]        cfg_lock_win,
  input logic [BW_W-1:0]         sel_bw,
  input logic [2:0]              sel_damp,
  input logic [1:0]              sel_gain,
  input logic [1:0]              sel_src,
  input logic                    tight_lock,
  input logic                    win_cfg_err
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic [ERR_W-1:0] mag_now;
  assign mag_now = err_data[ERR_W-1] ? ERR_W'(-err_data) : ERR_W'(err_data);

  // R5: tight lock implies the locked flag was set at the deciding edge
  p_tight_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tight_lock |-> $past(phase_locked));

  // R4: hysteresis entry only from a fine-magnitude sample
  p_hyst_fine_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tight_lock) && $past(cfg_hyst_en)) |->
      ($past(mag_now) < ERR_W'(2)));

  // R6: region code agrees with the tight-lock flag
  p_src_tight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> ((sel_src == 2'b10) == tight_lock));

  // R9: no event -> outputs hold
  p_hold_no_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((age == 2'd3) && !$past(err_valid && err_ready) &&
     ($past(phase_locked, 1) == $past(phase_locked, 2))) |->
      ($stable(sel_bw) && $stable(sel_damp) && $stable(sel_gain) &&
       $stable(sel_src) && $stable(tight_lock)));

  // R8: window error flag tracks a zero window field one cycle later
  p_win_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> (win_cfg_err == ($past(cfg_lock_win) == '0)));

  // R10: ready stays high once raised
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_ready) |-> err_ready);
endmodule

bind dpll_tlk_select dpll_tlk_checker #(.ERR_W(ERR_W), .WIN_W(WIN_W), .BW_W(BW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
  .err_data(err_data), .phase_locked(phase_locked), .cfg_hyst_en(cfg_hyst_en),
  .cfg_lock_win(cfg_lock_win), .sel_bw(sel_bw), .sel_damp(sel_damp),
  .sel_gain(sel_gain), .sel_src(sel_src), .tight_lock(tight_lock),
  .win_cfg_err(win_cfg_err)
);

// File: tb/dpll_tlk_select_tb_top.sv
`timescale 1ns/100ps
module dpll_tlk_select_tb_top;
  localparam int ERR_W = 12;

  typedef struct packed {
    logic [3:0] bw;
    logic [2:0] damp;
    logic [1:0] gain;
    logic [1:0] src;
    logic       tight;
    logic       inwin;
    logic       werr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic err_ready;
  logic signed [ERR_W-1:0] err_data = '0;
  logic phase_locked = 1'b0;
  logic [1:0] cfg_gain = 2'b01;
  logic [2:0] cfg_tl_bw = 3'b011;
  logic [2:0] cfg_tl_damp = 3'b000;
  logic cfg_hyst_en = 1'b0;
  logic [6:0] cfg_tl_thr = 7'd8;
  logic cfg_fast_lock = 1'b0;
  logic [3:0] cfg_lck_bw = 4'h5;
  logic [2:0] cfg_lck_damp = 3'd3;
  logic [3:0] cfg_acq_bw = 4'hA;
  logic [2:0] cfg_acq_damp = 3'd4;
  logic [7:0] cfg_lock_win = 8'h3F;
  logic [3:0] sel_bw;
  logic [2:0] sel_damp;
  logic [1:0] sel_gain, sel_src;
  logic tight_lock, in_window, win_cfg_err;

  always #2.5 clk = ~clk;

  dpll_tlk_select dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .phase_locked(phase_locked), .cfg_gain(cfg_gain),
    .cfg_tl_bw(cfg_tl_bw), .cfg_tl_damp(cfg_tl_damp), .cfg_hyst_en(cfg_hyst_en),
    .cfg_tl_thr(cfg_tl_thr), .cfg_fast_lock(cfg_fast_lock),
    .cfg_lck_bw(cfg_lck_bw), .cfg_lck_damp(cfg_lck_damp),
    .cfg_acq_bw(cfg_acq_bw), .cfg_acq_damp(cfg_acq_damp),
    .cfg_lock_win(cfg_lock_win), .sel_bw(sel_bw), .sel_damp(sel_damp),
    .sel_gain(sel_gain), .sel_src(sel_src), .tight_lock(tight_lock),
    .in_window(in_window), .win_cfg_err(win_cfg_err)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // ---------------- reference model (from the requirements) -------------
  exp_t m;
  logic m_lq;
  logic m_ready;

  function automatic int unsigned magf(logic signed [ERR_W-1:0] e);
    int v = int'(e);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m = '{bw:4'd0, damp:3'd0, gain:2'b01, src:2'b01, tight:1'b0, inwin:1'b0, werr:1'b0};
      m_lq = 1'b0;
      m_ready = 1'b0;
    end else begin
      logic acc, ev, nt;
      int unsigned mg, thr, win;
      acc = err_valid && m_ready;
      ev  = acc || (phase_locked != m_lq);
      mg  = magf(err_data);
      thr = cfg_tl_thr + 2;
      win = (cfg_lock_win == 0) ? 1 : cfg_lock_win;
      nt  = m.tight;
      if (!phase_locked) nt = 1'b0;
      else if (acc) begin
        if (m.tight) begin if (mg > thr) nt = 1'b0; end
        else if (cfg_hyst_en ? (mg < 2) : (mg < thr)) nt = 1'b1;
      end
      if (ev) begin
        m.gain = cfg_gain;
        if (nt) begin
          m.src  = 2'b10;
          m.bw   = (cfg_tl_bw == 0) ? cfg_lck_bw : {1'b0, cfg_tl_bw};
          m.damp = (cfg_tl_damp == 0 || cfg_tl_damp > 5) ? cfg_lck_damp : cfg_tl_damp;
        end else if (cfg_fast_lock && !phase_locked) begin
          m.src = 2'b00; m.bw = cfg_acq_bw; m.damp = cfg_acq_damp;
        end else begin
          m.src = 2'b01; m.bw = cfg_lck_bw; m.damp = cfg_lck_damp;
        end
      end
      m.tight = nt;
      if (acc) m.inwin = (mg <= win);
      m.werr = (cfg_lock_win == 0);
      m_lq = phase_locked;
      m_ready = 1'b1;
    end
  end

  // ---------------- scoreboard ----------------
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic step(input logic lk, input logic v, input int e, input string tag);
    @(negedge clk);
    phase_locked = lk;
    err_valid = v;
    err_data = ERR_W'(e);
    @(posedge clk);
    #1;
    exp_q.push_back(m);
    tag_q.push_back(tag);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t  x;
        exp_t  a;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{bw:sel_bw, damp:sel_damp, gain:sel_gain, src:sel_src,
              tight:tight_lock, inwin:in_window, werr:win_cfg_err};
        checks++;
        if (a !== x) begin
          fails++;
          $display("FAIL %s: got bw=%h damp=%0d gain=%0d src=%0d tl=%0b win=%0b werr=%0b exp bw=%h damp=%0d gain=%0d src=%0d tl=%0b win=%0b werr=%0b",
                   t, a.bw, a.damp, a.gain, a.src, a.tight, a.inwin, a.werr,
                   x.bw, x.damp, x.gain, x.src, x.tight, x.inwin, x.werr);
        end
      end
    end
  end

  task automatic check_bit(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0b exp %0b", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1: reset values, ready low in reset (R1 / R10)
    check_bit(err_ready, 1'b0, "R1 ready in reset");
    check_bit(tight_lock, 1'b0, "R1 tight reset");
    check_bit(sel_src == 2'b01 && sel_gain == 2'b01 && sel_bw == 4'd0 &&
              sel_damp == 3'd0 && !in_window && !win_cfg_err, 1'b1, "R1 codes reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(err_ready, 1'b1, "R10 ready after reset");
    check_bit(sel_src == 2'b01 && sel_gain == 2'b01 && !tight_lock, 1'b1, "R1 after release");

    step(0, 1, 3,   "R5 unlocked sample no tight");
    cfg_fast_lock = 1'b1;
    step(0, 1, 100, "R7 fast lock acquisition");
    step(1, 0, 0,   "R7 lock edge to locked codes");
    step(1, 1, 9,   "R3 enter below T");
    step(1, 1, 10,  "R3 equal T holds tight");
    step(1, 1, -11, "R3 exit above T");
    step(1, 1, -10, "R3 equal T no entry");
    cfg_tl_bw = 3'd0; cfg_tl_damp = 3'b110;
    step(1, 1, 0,   "R6 zero bw and reserved damp fall back");
    cfg_tl_damp = 3'd2;
    step(1, 1, 1,   "R6 tight damping code");
    cfg_gain = 2'b11; cfg_lck_bw = 4'h7;
    step(1, 0, 0,   "R9 config change ignored");
    step(1, 1, 1,   "R2 gain follows on sample");
    cfg_hyst_en = 1'b1;
    step(1, 1, 40,  "R4 exit above T");
    step(1, 1, 5,   "R4 no entry at 5");
    step(1, 1, 2,   "R4 no entry at limit");
    step(1, 1, -1,  "R4 entry below limit");
    step(1, 1, 10,  "R4 hold at T");
    step(1, 1, 11,  "R4 exit above T");
    step(1, 1, 0,   "R4 re-entry");
    step(0, 0, 0,   "R5 unlock forces exit");
    step(0, 1, 0,   "R5 unlocked small error");
    cfg_lock_win = 8'd3;
    step(0, 1, 3,   "R8 inside window edge");
    step(0, 1, -4,  "R8 outside window");
    cfg_lock_win = 8'd0;
    step(0, 1, 1,   "R8 zero window as 1");
    step(0, 1, 2,   "R8 zero window outside");
    cfg_lock_win = 8'h3F;
    step(1, 1, -2048, "R8 most negative error");
    step(1, 1, 63,  "R8 window top");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule